// File: doc/BRIEF.md
# Serial User Flash Access Controller

This block models a small non-volatile user memory of 512 words of 16 bits and places it behind two serial shift registers. One register holds a 9-bit word address and the other holds a 16-bit data word. Each register has its own clock, shift-enable, serial input and serial output. Software or a host state machine loads an address bit by bit. It then loads the data register either from the array, for a read, or from its serial input, before a program. A clock edge on the address register with the shift-enable low steps the address forward, so sequential reads need no reload.

Program and erase are timed operations. A rising request starts a countdown measured in system clock cycles, and `busy` stays high for the whole countdown. The countdown only advances while the oscillator enable is high. The array behaves like flash. Erased words read as all ones. A program can only clear bits. An erase restores a whole sector, and the sector is chosen by the top bit of the current address. All strobe inputs are sampled by the system clock `clk`. Each of them acts once, on the clock cycle in which it is first seen high.

Top module: `ufmSerialFlash`

## Requirements
- R1: After reset every array word reads FFFFh, `busy` is 0, the address register is 000h and the data register is 0000h.
- R2: A rising `addrClk` with `addrShiftEn` high shifts the address left by one and puts `addrIn` in bit 0, so the address is loaded MSB first. `addrOut` always shows address bit 8.
- R3: A rising `addrClk` with `addrShiftEn` low adds one to the address. 1FFh steps to 000h.
- R4: A rising `dataClk` with `dataShiftEn` low loads the data register from the word at the current address. With `dataShiftEn` high it shifts left, taking `dataIn` into bit 0. `dataOut` always shows data bit 15.
- R5: A rising `progReq` while idle with `oscEn` high makes `busy` go high on the next cycle and keeps it high for PROG_CYCLES cycles. After that the word at the current address becomes its old value AND the data register.
- R6: A rising `eraseReq` under the same conditions holds `busy` for ERASE_CYCLES cycles. After that every word whose address bit 8 equals the current address bit 8 reads FFFFh, and the other sector is unchanged. If both requests rise in the same cycle, program wins.
- R7: A request edge seen while `busy` is high is ignored and does not start later.
- R8: A request edge seen while `oscEn` is low is ignored, and `busy` stays low.
- R9: While an operation runs with `oscEn` low, its countdown pauses and `busy` stays high. The operation then lasts one extra cycle for every paused cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all other inputs |
| rstN | input | 1 | Asynchronous active-low reset |
| addrClk | input | 1 | Address register clock; acts on its rising edge |
| addrShiftEn | input | 1 | High: shift the address; low: increment it |
| addrIn | input | 1 | Serial address input |
| addrOut | output | 1 | Address bit 8 |
| dataClk | input | 1 | Data register clock; acts on its rising edge |
| dataShiftEn | input | 1 | High: shift the data; low: load it from the array |
| dataIn | input | 1 | Serial data input |
| dataOut | output | 1 | Data bit 15 |
| progReq | input | 1 | Program request; a rising edge starts a program |
| eraseReq | input | 1 | Erase request; a rising edge starts a sector erase |
| oscEn | input | 1 | Enables the operation timer |
| busy | output | 1 | High while a program or erase runs |

## Verification
A corrupt address register appears at `addrOut` within one address rotation, which takes nine shift edges. It also surfaces as a wrong word on the next data load. A wrong array word becomes visible at `dataOut` sixteen data clocks after a load. The sweeps load and compare every location, so a word damaged by a stray write or an erase of the wrong sector is caught on the next sweep. A timer or state fault changes the number of cycles for which `busy` is high, and that count is measured on every operation. It can also leave `busy` set or clear in the cycle after a request edge.

// File: rtl/ufmPkg.sv
package ufmPkg;

  typedef struct packed {
    logic addrShift;
    logic addrInc;
    logic dataShift;
    logic dataLoad;
    logic progCommit;
    logic eraseCommit;
  } ufmStrobe_t;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } ufmOp_t;

endpackage

// File: rtl/ufmControl.sv
module ufmControl #(
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 20,
  localparam int MAX_CYCLES  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
  localparam int CNT_W       = $clog2(MAX_CYCLES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 addrClk,
  input  logic                 addrShiftEn,
  input  logic                 dataClk,
  input  logic                 dataShiftEn,
  input  logic                 progReq,
  input  logic                 eraseReq,
  input  logic                 oscEn,
  output ufmPkg::ufmStrobe_t   stb,
  output logic                 busy
);
  import ufmPkg::*;

  // edge detection on the four strobe-like inputs
  logic [3:0] rawIn, lastQ, rise;
  assign rawIn = {eraseReq, progReq, dataClk, addrClk};
  assign rise  = rawIn & ~lastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastQ <= '0;
    else       lastQ <= rawIn;
  end

  ufmOp_t           opState;
  logic [CNT_W-1:0] cnt;
  logic             progDone, eraseDone;

  assign progDone  = (opState == OP_PROG)  && oscEn && (cnt == CNT_W'(PROG_CYCLES - 1));
  assign eraseDone = (opState == OP_ERASE) && oscEn && (cnt == CNT_W'(ERASE_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opState <= OP_IDLE;
      cnt     <= '0;
    end else begin
      unique case (opState)
        OP_IDLE: begin
          cnt <= '0;
          if (oscEn && rise[2])      opState <= OP_PROG;
          else if (oscEn && rise[3]) opState <= OP_ERASE;
        end
        OP_PROG, OP_ERASE: begin
          if (progDone || eraseDone) begin
            opState <= OP_IDLE;
            cnt     <= '0;
          end else if (oscEn) begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: opState <= OP_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.addrShift   = rise[0] &  addrShiftEn;
    stb.addrInc     = rise[0] & ~addrShiftEn;
    stb.dataShift   = rise[1] &  dataShiftEn;
    stb.dataLoad    = rise[1] & ~dataShiftEn;
    stb.progCommit  = progDone;
    stb.eraseCommit = eraseDone;
  end

  assign busy = (opState != OP_IDLE);

endmodule

// File: rtl/ufmDatapath.sv
module ufmDatapath #(
  parameter int WORDS  = 512,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(WORDS),
  localparam int HALF   = WORDS / 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ufmPkg::ufmStrobe_t stb,
  input  logic               addrIn,
  input  logic               dataIn,
  output logic               addrOut,
  output logic               dataOut,
  output logic [ADDR_W-1:0]  addrCur
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              addrQ <= '0;
    else if (stb.addrShift) addrQ <= {addrQ[ADDR_W-2:0], addrIn};
    else if (stb.addrInc)   addrQ <= addrQ + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataQ <= '0;
    else if (stb.dataShift) dataQ <= {dataQ[DATA_W-2:0], dataIn};
    else if (stb.dataLoad)  dataQ <= mem[addrQ];
  end

  // array with flash semantics: program clears bits, erase sets a sector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (stb.progCommit) begin
      mem[addrQ] <= mem[addrQ] & dataQ;
    end else if (stb.eraseCommit) begin
      for (int i = 0; i < WORDS; i++)
        if ((i >= HALF) == addrQ[ADDR_W-1]) mem[i] <= '1;
    end
  end

  assign addrOut = addrQ[ADDR_W-1];
  assign dataOut = dataQ[DATA_W-1];
  assign addrCur = addrQ;

endmodule

// File: rtl/ufmSerialFlash.sv
module ufmSerialFlash #(
  parameter int WORDS        = 512,
  parameter int DATA_W       = 16,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 20,
  localparam int ADDR_W      = $clog2(WORDS)
) (
  input  logic clk,
  input  logic rstN,
  input  logic addrClk,
  input  logic addrShiftEn,
  input  logic addrIn,
  output logic addrOut,
  input  logic dataClk,
  input  logic dataShiftEn,
  input  logic dataIn,
  output logic dataOut,
  input  logic progReq,
  input  logic eraseReq,
  input  logic oscEn,
  output logic busy
);

  ufmPkg::ufmStrobe_t stb;
  logic [ADDR_W-1:0]  addrCur;

  ufmControl #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addrClk    (addrClk),
    .addrShiftEn(addrShiftEn),
    .dataClk    (dataClk),
    .dataShiftEn(dataShiftEn),
    .progReq    (progReq),
    .eraseReq   (eraseReq),
    .oscEn      (oscEn),
    .stb        (stb),
    .busy       (busy)
  );

  ufmDatapath #(
    .WORDS (WORDS),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .addrIn (addrIn),
    .dataIn (dataIn),
    .addrOut(addrOut),
    .dataOut(dataOut),
    .addrCur(addrCur)
  );

endmodule

// File: rtl/ufmSerialFlash_chk.sv
module ufmSerialFlash_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrClk,
  input logic              addrShiftEn,
  input logic              addrIn,
  input logic              progReq,
  input logic              eraseReq,
  input logic              oscEn,
  input logic              busy,
  input logic [ADDR_W-1:0] addrCur
);

  logic lastAddrClk, lastProg, lastErase;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastAddrClk <= 1'b0;
      lastProg    <= 1'b0;
      lastErase   <= 1'b0;
    end else begin
      lastAddrClk <= addrClk;
      lastProg    <= progReq;
      lastErase   <= eraseReq;
    end
  end

  logic addrEdge, reqEdge;
  assign addrEdge = addrClk & ~lastAddrClk;
  assign reqEdge  = (progReq & ~lastProg) | (eraseReq & ~lastErase);

  a_r2_addr_shift: assert property (@(posedge clk) disable iff (!rstN)
    (addrEdge && addrShiftEn) |=> addrCur == {$past(addrCur[ADDR_W-2:0]), $past(addrIn)});

  a_r3_addr_increment: assert property (@(posedge clk) disable iff (!rstN)
    (addrEdge && !addrShiftEn) |=> addrCur == ADDR_W'($past(addrCur) + ADDR_W'(1)));

  a_r5_busy_starts: assert property (@(posedge clk) disable iff (!rstN)
    (reqEdge && !busy && oscEn) |=> busy);

  a_r8_no_start_without_osc: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !oscEn) |=> !busy);

  a_r9_pause_holds_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !oscEn) |=> busy);

  a_r3_addr_still_without_edge: assert property (@(posedge clk) disable iff (!rstN)
    !addrEdge |=> $stable(addrCur));

endmodule

bind ufmSerialFlash ufmSerialFlash_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .addrClk    (addrClk),
  .addrShiftEn(addrShiftEn),
  .addrIn     (addrIn),
  .progReq    (progReq),
  .eraseReq   (eraseReq),
  .oscEn      (oscEn),
  .busy       (busy),
  .addrCur    (addrCur)
);

// File: tb/ufmSerialFlash_tb.sv
module ufmSerialFlash_tb;
  localparam int WORDS = 512;
  localparam int PROG_CYCLES = 8;
  localparam int ERASE_CYCLES = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrClk = 0, addrShiftEn = 0, addrIn = 0;
  logic dataClk = 0, dataShiftEn = 0, dataIn = 0;
  logic progReq = 0, eraseReq = 0, oscEn = 1;
  logic addrOut, dataOut, busy;

  always #4 clk = ~clk;

  ufmSerialFlash #(.WORDS(WORDS), .DATA_W(16), .PROG_CYCLES(PROG_CYCLES),
                   .ERASE_CYCLES(ERASE_CYCLES)) u_dut (
    .clk(clk), .rstN(rstN), .addrClk(addrClk), .addrShiftEn(addrShiftEn),
    .addrIn(addrIn), .addrOut(addrOut), .dataClk(dataClk),
    .dataShiftEn(dataShiftEn), .dataIn(dataIn), .dataOut(dataOut),
    .progReq(progReq), .eraseReq(eraseReq), .oscEn(oscEn), .busy(busy));

  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 0;
  logic [15:0] model [WORDS];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 40503) ^ 16'h3C5A;
  endfunction

  task automatic pulseAddr();
    @(negedge clk) addrClk = 1;
    @(negedge clk) addrClk = 0;
  endtask

  task automatic pulseData();
    @(negedge clk) dataClk = 1;
    @(negedge clk) dataClk = 0;
  endtask

  task automatic loadAddr(input logic [8:0] a);
    addrShiftEn = 1;
    for (int i = 8; i >= 0; i--) begin
      addrIn = a[i];
      pulseAddr();
    end
    addrShiftEn = 0;
  endtask

  // rotate nine times: reads the address and leaves it unchanged
  task automatic readAddr(output logic [8:0] a);
    addrShiftEn = 1;
    for (int i = 8; i >= 0; i--) begin
      a[i] = addrOut;
      addrIn = addrOut;
      pulseAddr();
    end
    addrShiftEn = 0;
  endtask

  task automatic writeData(input logic [15:0] d);
    dataShiftEn = 1;
    for (int i = 15; i >= 0; i--) begin
      dataIn = d[i];
      pulseData();
    end
    dataShiftEn = 0;
  endtask

  task automatic readWord(output logic [15:0] d);
    dataShiftEn = 0;
    pulseData();
    dataShiftEn = 1;
    dataIn = 0;
    for (int i = 15; i >= 0; i--) begin
      d[i] = dataOut;
      if (i > 0) pulseData();
    end
    dataShiftEn = 0;
  endtask

  task automatic runOp(input bit isErase, input int pauseAt, input int pauseLen,
                       output int cnt);
    @(negedge clk);
    if (isErase) eraseReq = 1; else progReq = 1;
    cnt = 0;
    @(negedge clk);
    while (busy && cnt < 2000) begin
      cnt++;
      if (cnt == pauseAt) oscEn = 0;
      if (cnt == pauseAt + pauseLen) oscEn = 1;
      @(negedge clk);
    end
    progReq = 0;
    eraseReq = 0;
  endtask

  task automatic sweep(input string req);
    logic [15:0] d;
    logic [8:0] a;
    loadAddr(9'h000);
    for (int i = 0; i < WORDS; i++) begin
      readWord(d);
      chk(req, {16'h0, d}, {16'h0, model[i]});
      pulseAddr();
    end
    readAddr(a);
    chk("R3 wrap after full sweep", {23'h0, a}, 32'h0);
  endtask

  initial begin
    logic [15:0] d;
    logic [8:0] a;
    int cnt;
    for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy after reset", {31'h0, busy}, 0);
    chk("R1 addrOut after reset", {31'h0, addrOut}, 0);
    chk("R1 dataOut after reset", {31'h0, dataOut}, 0);
    readAddr(a);
    chk("R1 address after reset", {23'h0, a}, 0);

    // R2: address load and readback; R1/R4 erased read
    loadAddr(9'h1A5);
    chk("R2 addrOut shows bit 8", {31'h0, addrOut}, 1);
    readAddr(a);
    chk("R2 address readback", {23'h0, a}, 32'h1A5);
    readWord(d);
    chk("R1 erased word reads ones", {16'h0, d}, 32'hFFFF);

    // R3: increment wraps
    loadAddr(9'h1FE);
    pulseAddr();
    readAddr(a);
    chk("R3 increment", {23'h0, a}, 32'h1FF);
    pulseAddr();
    readAddr(a);
    chk("R3 wrap 1FF to 000", {23'h0, a}, 0);

    // R5: program every word using auto-increment
    loadAddr(9'h000);
    for (int i = 0; i < WORDS; i++) begin
      writeData(pat(i));
      runOp(0, 0, 0, cnt);
      chk("R5 program busy length", cnt, PROG_CYCLES);
      model[i] = model[i] & pat(i);
      pulseAddr();
    end
    sweep("R4 readback after programming");

    // R5: second program ANDs bits
    loadAddr(9'h003);
    writeData(16'h0FF0);
    runOp(0, 0, 0, cnt);
    model[3] = model[3] & 16'h0FF0;
    readWord(d);
    chk("R5 program ANDs into old value", {16'h0, d}, {16'h0, model[3]});

    // R7: erase request raised during a program is ignored
    loadAddr(9'h007);
    writeData(16'h0000);
    @(negedge clk) progReq = 1;
    repeat (3) @(negedge clk);
    chk("R7 busy during program", {31'h0, busy}, 1);
    eraseReq = 1;
    while (busy) @(negedge clk);
    repeat (30) @(negedge clk);
    chk("R7 no late erase start", {31'h0, busy}, 0);
    progReq = 0;
    eraseReq = 0;
    model[7] = 16'h0000;
    readWord(d);
    chk("R7 programmed word", {16'h0, d}, 0);
    pulseAddr();
    readWord(d);
    chk("R7 sector not erased", {16'h0, d}, {16'h0, model[8]});

    // R8: requests with oscillator off are ignored
    loadAddr(9'h009);
    writeData(16'h0000);
    @(negedge clk) oscEn = 0;
    progReq = 1;
    eraseReq = 1;
    repeat (6) @(negedge clk);
    chk("R8 no busy with osc off", {31'h0, busy}, 0);
    oscEn = 1;
    repeat (6) @(negedge clk);
    chk("R8 held request does not start later", {31'h0, busy}, 0);
    progReq = 0;
    eraseReq = 0;
    readWord(d);
    chk("R8 word unchanged", {16'h0, d}, {16'h0, model[9]});

    // R9: pause extends the operation
    loadAddr(9'h00A);
    writeData(16'h0000);
    runOp(0, 3, 10, cnt);
    chk("R9 paused program length", cnt, PROG_CYCLES + 10);
    model[10] = 16'h0000;
    readWord(d);
    chk("R9 paused program result", {16'h0, d}, 0);

    // R6: erase the upper sector only
    loadAddr(9'h105);
    runOp(1, 0, 0, cnt);
    chk("R6 erase busy length", cnt, ERASE_CYCLES);
    for (int i = WORDS / 2; i < WORDS; i++) model[i] = 16'hFFFF;
    sweep("R6 readback after sector erase");

    finished = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule